// File: doc/BRIEF.md
# Two-wire command slave decoder

This block is the digital front end of a slave on a two-wire open-drain bus. SCL and SDA are synchronised into a faster system clock, and the block finds the bus edges and the start and stop conditions in that clock domain. It shifts in an 8-bit address and compares it with a fixed type code plus four strap inputs. It answers with an acknowledge only when the address matches and no internal store is running.

After a matching address, the block captures an instruction byte and splits it into a four-bit opcode, a two-bit register select and a two-bit pot select. The opcode decides how the transaction goes on:
- It may end after the instruction.
- It may take one more data byte from the master.
- It may send one data byte to the master.
- It may switch into a stepping mode, where every further SCL clock moves a wiper one step.

Register actions reach an external register bank as single-cycle strobes. Read data comes back from that bank on a parallel input. SDA is modelled as an open-drain driver: one output enable that pulls the line low, plus an input sample of the line.

Top module: `twc_slave`

## Requirements
- R1: SDA falling while SCL is high is a start. A start at any point, including in the middle of a byte, aborts the transaction and restarts address reception. SDA rising while SCL is high is a stop. A stop returns the block to idle with `sda_oe` low.
- R2: The first byte after a start is the address, MSB first. Bits 7..4 must be 0101 and bits 3..0 must equal `strap_addr`. On a match the block drives `sda_oe` high for the ninth SCL clock. On a mismatch it never drives SDA and raises no strobe until the next start.
- R3: While `store_busy` is high when the address byte completes, the block does not acknowledge the address, even if the address matches.
- R4: The second byte is always acknowledged. Its bits 7..4 appear on `cmd_op`, bits 3..2 on `cmd_reg` and bits 1..0 on `cmd_pot`, and they hold until the next instruction byte.
- R5: Opcodes 1101, 1110, 0001 and 1000 produce exactly one `cmd_valid` pulse, at the end of the instruction acknowledge. No data byte follows.
- R6: Opcodes 1010 and 1100 take a third byte from the master and acknowledge it. At the end of that acknowledge they pulse `cmd_valid` once, with `cmd_wdata` equal to bits 5..0 of the byte. Bits 7..6 are dropped.
- R7: For opcodes 1001 and 1011, `rd_data` is sampled at the end of the instruction acknowledge. The block then sends the byte {0,0,rd_data} MSB first, pulling SDA low only for 0 bits. It releases SDA for the master's ninth clock, and it raises no `cmd_valid`.
- R8: After opcode 0010, each SCL clock that ends with a falling SCL edge gives one `step_valid` pulse. `step_up` equals SDA as sampled at that clock's rising edge (1 = up, 0 = down). A clock that ends in a stop gives no step.
- R9: Any other opcode is acknowledged at the instruction byte but causes no `cmd_valid` or `step_valid`.
- R10: `sda_oe` changes only in the cycle after a synchronised SCL falling edge, a start or a stop.
- R11: After reset `sda_oe`, `cmd_valid` and `step_valid` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line sample |
| sda_i | input | 1 | Bus data line sample |
| sda_oe | output | 1 | High pulls SDA low |
| strap_addr | input | 4 | Low nibble of the slave address |
| store_busy | input | 1 | Internal nonvolatile store in progress |
| cmd_valid | output | 1 | One-cycle register command strobe |
| cmd_op | output | 4 | Captured opcode |
| cmd_reg | output | 2 | Captured register select |
| cmd_pot | output | 2 | Captured pot select |
| cmd_wdata | output | 6 | Data value for write commands |
| rd_data | input | 6 | Read value from the bank for cmd_reg/cmd_pot |
| step_valid | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 = up |

## Verification
The assertions assume the master changes SDA only while SCL is low, except at start and stop. They also assume every bus level stays put for more system clocks than the synchroniser needs, so that each SCL edge is seen exactly once and in order with the SDA changes around it.

The bench holds each bus phase for eight system clocks. It moves SDA only after SCL has been low for a phase, except inside its start and stop tasks. Its open-drain line model combines the master's drive with `sda_oe`, so acknowledges and read bits are seen exactly as the master would see them.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b0101;

    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_DATA  = 4'b1011;
    localparam logic [3:0] OP_WR_DATA  = 4'b1100;
    localparam logic [3:0] OP_D2W      = 4'b1101;
    localparam logic [3:0] OP_W2D      = 4'b1110;
    localparam logic [3:0] OP_ALL_D2W  = 4'b0001;
    localparam logic [3:0] OP_ALL_W2D  = 4'b1000;
    localparam logic [3:0] OP_STEP     = 4'b0010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_SKIP
    } twc_state_e;

    typedef enum logic [2:0] {
        OC_NONE, OC_XFER, OC_WRITE, OC_READ, OC_STEP
    } twc_class_e;

endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/twc_decode.sv
module twc_decode
    import twc_pkg::*;
(
    input  logic [3:0]  op,
    output twc_class_e  cls
);
    always_comb begin
        case (op)
            OP_RD_WIPER, OP_RD_DATA:                  cls = OC_READ;
            OP_WR_WIPER, OP_WR_DATA:                  cls = OC_WRITE;
            OP_D2W, OP_W2D, OP_ALL_D2W, OP_ALL_W2D:   cls = OC_XFER;
            OP_STEP:                                  cls = OC_STEP;
            default:                                  cls = OC_NONE;
        endcase
    end
endmodule

// File: rtl/twc_slave.sv
module twc_slave
    import twc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [3:0]        strap_addr,
    input  logic              store_busy,
    output logic              cmd_valid,
    output logic [3:0]        cmd_op,
    output logic [1:0]        cmd_reg,
    output logic [1:0]        cmd_pot,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] rd_data,
    output logic              step_valid,
    output logic              step_up
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK  = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        twc_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               oe;
        logic [3:0]         op;
        logic [1:0]         rsel;
        logic [1:0]         psel;
        logic [DATA_W-1:0]  wdata;
        logic               cv;
        logic               sv;
        logic               sup;
        logic               bit_s;
    } twc_regs_t;

    twc_regs_t d, q;

    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_ev, stop_ev, addr_hit;
    twc_class_e op_cls;
    logic [BYTE_W-1:0] tx_byte;

    twc_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i),
        .level(scl_s), .rise(scl_rise), .fall(scl_fall));

    twc_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i),
        .level(sda_s), .rise(sda_rise), .fall(sda_fall));

    twc_decode u_decode (.op(q.op), .cls(op_cls));

    // SCL high in this and the previous cycle while SDA moves
    assign start_ev = scl_s & ~scl_rise & sda_fall;
    assign stop_ev  = scl_s & ~scl_rise & sda_rise;
    assign addr_hit = (q.sh[7:4] == TYPE_CODE) && (q.sh[3:0] == strap_addr);
    assign tx_byte  = BYTE_W'(rd_data);

    always_comb begin
        d    = q;
        d.cv = 1'b0;
        d.sv = 1'b0;
        if (stop_ev) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_ev) begin
            d.st  = ST_ADDR;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            if (scl_rise) d.bit_s = sda_s;
            case (q.st)
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise && q.cnt < LAST) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                    if (scl_fall && q.cnt == LAST) begin
                        if (q.st == ST_ADDR && !(addr_hit && !store_busy)) begin
                            d.st = ST_SKIP;
                        end else begin
                            d.oe  = 1'b1;
                            d.cnt = ACK;
                        end
                        if (q.st == ST_INSTR) begin
                            d.op   = q.sh[7:4];
                            d.rsel = q.sh[3:2];
                            d.psel = q.sh[1:0];
                        end
                    end
                    if (scl_fall && q.cnt == ACK) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        case (q.st)
                            ST_ADDR:  d.st = ST_INSTR;
                            ST_INSTR: begin
                                case (op_cls)
                                    OC_XFER: begin
                                        d.cv = 1'b1;
                                        d.st = ST_SKIP;
                                    end
                                    OC_WRITE: d.st = ST_WDATA;
                                    OC_READ: begin
                                        d.st = ST_RDATA;
                                        d.sh = tx_byte;
                                        d.oe = ~tx_byte[BYTE_W-1];
                                    end
                                    OC_STEP: d.st = ST_STEP;
                                    default: d.st = ST_SKIP;
                                endcase
                            end
                            default: begin
                                d.cv    = 1'b1;
                                d.wdata = q.sh[DATA_W-1:0];
                                d.st    = ST_SKIP;
                            end
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && q.cnt < LAST) d.cnt = q.cnt + CNT_W'(1);
                    if (scl_fall) begin
                        if (q.cnt == ACK) begin
                            d.st = ST_SKIP;
                        end else if (q.cnt == LAST) begin
                            d.oe  = 1'b0;
                            d.cnt = ACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_STEP: begin
                    if (scl_fall) begin
                        d.sv  = 1'b1;
                        d.sup = q.bit_s;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q       <= d;
        end
    end

    assign sda_oe     = q.oe;
    assign cmd_valid  = q.cv;
    assign cmd_op     = q.op;
    assign cmd_reg    = q.rsel;
    assign cmd_pot    = q.psel;
    assign cmd_wdata  = q.wdata;
    assign step_valid = q.sv;
    assign step_up    = q.sup;

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.st == ST_IDLE && !sda_oe));                                 // R1
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (q.st == ST_ADDR && q.cnt == '0 && !sda_oe));   // R1
    AST_ADDR_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && q.cnt == LAST && scl_fall && !start_ev && !stop_ev && !addr_hit)
        |=> !sda_oe);                                                              // R2
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && q.cnt == LAST && scl_fall && !start_ev && !stop_ev && store_busy)
        |=> (!sda_oe && q.st == ST_SKIP));                                         // R3
    AST_STEP_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (q.st == ST_STEP));                                         // R8
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && step_valid));                                               // R5
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));              // R10
endmodule

// File: tb/twc_slave_bench.sv
module twc_slave_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic store_busy = 1'b0;
    logic [3:0] strap_addr = 4'h9;
    logic sda_oe, cmd_valid, step_valid, step_up;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg, cmd_pot;
    logic [5:0] cmd_wdata, rd_data;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state: expected strobes in order
    logic [7:0] exp_cmd[$];
    int         exp_w[$];
    bit         exp_step[$];

    always #10 clk = ~clk;

    function automatic logic [5:0] bank_model(input logic [1:0] p, input logic [1:0] r);
        return {p, r, 2'b01} ^ 6'h15;
    endfunction

    assign rd_data = bank_model(cmd_pot, cmd_reg);

    twc_slave u_twc_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_addr(strap_addr), .store_busy(store_busy), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata),
        .rd_data(rd_data), .step_valid(step_valid), .step_up(step_up));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every clock: compare strobes with the model's queues
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_cmd.size() == 0) begin
                check(1'b0, "R9 unexpected cmd_valid", {cmd_op, cmd_reg, cmd_pot}, 0);
            end else begin
                automatic logic [7:0] e = exp_cmd.pop_front();
                automatic int w = exp_w.pop_front();
                check({cmd_op, cmd_reg, cmd_pot} == e, "R5/R6 cmd fields",
                      {cmd_op, cmd_reg, cmd_pot}, e);
                if (w >= 0) check(cmd_wdata == w[5:0], "R6 cmd_wdata", cmd_wdata, w);
            end
        end
        if (rst_n && step_valid) begin
            if (exp_step.size() == 0) begin
                check(1'b0, "R8 unexpected step", step_up, 0);
            end else begin
                automatic bit s = exp_step.pop_front();
                check(step_up == s, "R8 step direction", step_up, s);
            end
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        acked = (sda_line == 1'b0);
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl_m = 1'b1; qwait();
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        qwait();
        sda_m = ~mack; qwait();
        scl_m = 1'b1;  qwait();
        scl_m = 1'b0;  qwait();
        sda_m = 1'b1;
    endtask

    task automatic open_cmd(input logic [7:0] instr, input string tag);
        bit a;
        bus_start();
        send_byte(8'h59, a);
        check(a, {tag, " R2 address ack"}, a, 1);
        send_byte(instr, a);
        check(a, {tag, " R4 instruction ack"}, a, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        // R11 reset state
        check(sda_oe == 1'b0, "R11 sda_oe at reset", sda_oe, 0);
        check(cmd_valid == 1'b0 && step_valid == 1'b0, "R11 strobes at reset",
              {cmd_valid, step_valid}, 0);
        rst_n = 1'b1;
        qwait();

        // R6 write wiper, data 0x2B
        exp_cmd.push_back(8'b1010_00_10); exp_w.push_back(6'h2B);
        open_cmd(8'b1010_00_10, "wr wiper");
        check(cmd_op == 4'hA && cmd_reg == 2'd0 && cmd_pot == 2'd2, "R4 field split",
              {cmd_op, cmd_reg, cmd_pot}, 8'hA2);
        send_byte(8'h2B, a);
        check(a, "R6 data ack", a, 1);
        bus_stop();
        check(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);

        // R6 write data register, top bits dropped
        exp_cmd.push_back(8'b1100_01_11); exp_w.push_back(6'h05);
        open_cmd(8'b1100_01_11, "wr data");
        send_byte(8'hC5, a);
        check(a, "R6 data ack", a, 1);
        bus_stop();

        // R2 wrong strap nibble, then wrong type code
        bus_start();
        send_byte(8'h58, a);
        check(!a, "R2 strap mismatch no ack", a, 0);
        send_byte(8'b1101_00_00, a);
        check(!a, "R2 silent after mismatch", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h69, a);
        check(!a, "R2 type mismatch no ack", a, 0);
        bus_stop();

        // R3 busy store blocks the address ack
        store_busy = 1'b1;
        bus_start();
        send_byte(8'h59, a);
        check(!a, "R3 no ack while busy", a, 0);
        bus_stop();
        store_busy = 1'b0;

        // R5 two-byte transfers
        exp_cmd.push_back(8'b1101_11_01); exp_w.push_back(-1);
        open_cmd(8'b1101_11_01, "xfer d2w");
        bus_stop();
        exp_cmd.push_back(8'b0001_10_00); exp_w.push_back(-1);
        open_cmd(8'b0001_10_00, "global d2w");
        bus_stop();
        exp_cmd.push_back(8'b1110_01_10); exp_w.push_back(-1);
        open_cmd(8'b1110_01_10, "xfer w2d");
        bus_stop();

        // R7 reads
        open_cmd(8'b1001_00_01, "rd wiper");
        recv_byte(1'b0, rb);
        check(rb == {2'b00, bank_model(2'd1, 2'd0)}, "R7 read wiper byte", rb,
              {2'b00, bank_model(2'd1, 2'd0)});
        bus_stop();
        open_cmd(8'b1011_10_11, "rd data");
        recv_byte(1'b0, rb);
        check(rb == {2'b00, bank_model(2'd3, 2'd2)}, "R7 read data byte", rb,
              {2'b00, bank_model(2'd3, 2'd2)});
        bus_stop();

        // R9 unknown opcodes acknowledged without action
        open_cmd(8'b0000_11_11, "unknown 0000");
        bus_stop();
        open_cmd(8'b1111_01_01, "unknown 1111");
        bus_stop();

        // R8 stepping, the stop clock must not step
        open_cmd(8'b0010_00_11, "step");
        exp_step.push_back(1'b1); exp_step.push_back(1'b1);
        exp_step.push_back(1'b0); exp_step.push_back(1'b1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();

        // R1 start in the middle of a byte restarts address reception
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        exp_cmd.push_back(8'b1000_11_00); exp_w.push_back(-1);
        open_cmd(8'b1000_11_00, "R1 repeated start");
        bus_stop();

        qwait(); qwait();
        check(exp_cmd.size() == 0, "R5 all command strobes seen", exp_cmd.size(), 0);
        check(exp_step.size() == 0, "R8 all steps seen", exp_step.size(), 0);
        check(sda_oe == 1'b0, "R1 idle bus released", sda_oe, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule